// File: doc/BRIEF.md
# Delta-Sigma Calibration Sequencer

This block steps a delta-sigma converter through its calibration modes one conversion cycle at a time. A 3-bit mode field from a command register chooses the mode. A single-clock strobe marks each conversion-cycle boundary, and a flag says whether the converter runs in slave mode. From these inputs the block drives four things: the front-end input selector, the offset-calibrate and gain-calibrate enables, an active-low data-ready flag, and a one-clock request that tells the register to clear its mode field back to normal.

Three calibration flows are supported.

- **Pseudo system calibration.** An offset phase runs on the live input. A gain phase follows against the reference. The mode then clears itself and a filter refill runs.
- **Background calibration.** This flow loops without end. It alternates an offset phase on shorted inputs and a full-scale phase on the reference. Each phase is followed by a refill and then one valid-data cycle.
- **System full-scale calibration.** A gain phase runs on the live input, and normal operation resumes on the very next cycle.

Every phase is counted in whole conversion cycles, and data-ready stays high through all of them. After reset the block starts with a filter refill.

Top module: `calseq_top`

## Requirements
- R1: After reset, `drdy_n` is 1, both enables are 0, `mode_clr` is 0 and `in_sel` is 00 (input). `drdy_n` stays 1 until the third strobe after reset, and goes to 0 at that strobe.
- R2: In normal operation, mode codes other than 100, 101 and 011 start nothing. After each strobe the outputs show input select, both enables 0 and `drdy_n` 0.
- R3: From the strobe that starts a calibration mode until that mode's refill ends, `drdy_n` is 1. Outside a valid-data cycle, `drdy_n` is never 0 while an enable is 1.
- R4: Code 100, seen at a strobe in normal operation, starts pseudo system calibration. Its offset phase has `in_sel`=00 and `ofs_cal_en`=1, and lasts 3 strobe periods, or 4 when `slave_mode`=1.
- R5: The pseudo system gain phase has `in_sel`=10 (reference) and `gain_cal_en`=1 and lasts 3 periods. At the strobe that ends it, `mode_clr` pulses high for exactly one clock.
- R6: After the pseudo system gain phase, 3 periods run with input select, both enables 0 and `drdy_n`=1. At the next strobe, `drdy_n` goes to 0.
- R7: Code 101 starts background calibration. Its offset phases have `in_sel`=01 (shorted) and `ofs_cal_en`=1. The first offset phase after entry lasts 4 periods when `slave_mode`=1 and 3 otherwise. Every later offset phase lasts 3.
- R8: After each background calibration phase, 3 refill periods run with `drdy_n`=1. Then exactly one period follows with `drdy_n`=0.
- R9: In background mode, the valid cycle after an offset phase is followed by a 3-period full-scale phase (`in_sel`=10, `gain_cal_en`=1), a refill and a valid cycle. The loop then returns to an offset phase. `mode_clr` never pulses in background mode.
- R10: In background mode, if the mode field no longer reads 101 at a strobe, the loop stops at that strobe. 3 refill periods with `drdy_n`=1 follow, and then normal operation resumes.
- R11: Code 011 starts system full-scale calibration. Its gain phase has `in_sel`=00 and `gain_cal_en`=1 and lasts 3 periods. At the next strobe, `drdy_n` goes to 0 and `mode_clr` pulses.
- R12: Outputs change only at a strobe. Clocks without a strobe change nothing, even when the mode field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | 3 | Mode field from the command register |
| conv_strobe | input | 1 | One-clock pulse at each conversion-cycle boundary |
| slave_mode | input | 1 | Converter runs in slave mode (longer first offset phase) |
| in_sel | output | 2 | Front-end select: 00 input, 01 shorted, 10 reference |
| ofs_cal_en | output | 1 | Offset calibration active |
| gain_cal_en | output | 1 | Gain / full-scale calibration active |
| drdy_n | output | 1 | Data ready, active low |
| mode_clr | output | 1 | One-clock request to clear the mode field to 000 |

## Verification
The bench steps through every phase one strobe at a time and checks the exact strobe at which each phase ends. A counter off by one would stretch or shorten the offset, gain and refill windows, and data-ready would fall a cycle early or late. Slave mode is run through two background offset phases. A design that applied the extra period every time would show a 4-period second offset, and one that never applied it would show a 3-period first. Other checks cover leaving background mode in the middle of a gain phase, the single-cycle return after system full-scale calibration, and the clear request. A design that missed the clear request, or sent it in background mode, would fail these checks, and so would one that reacted to a mode write without waiting for a strobe.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [2:0] {
        PH_NORM,
        PH_OFS,
        PH_GAIN,
        PH_FILL,
        PH_VALID
    } phase_e;

    typedef enum logic [1:0] {
        MD_NONE,
        MD_PSC,
        MD_BG,
        MD_SFS
    } run_e;

    typedef enum logic [1:0] {
        SEL_INPUT = 2'b00,
        SEL_SHORT = 2'b01,
        SEL_REF   = 2'b10
    } insel_e;

    localparam logic [2:0] CODE_NORMAL = 3'b000;
    localparam logic [2:0] CODE_PSC    = 3'b100;
    localparam logic [2:0] CODE_BG     = 3'b101;
    localparam logic [2:0] CODE_SFS    = 3'b011;

    typedef struct packed {
        phase_e phase;
        run_e   run;
        logic   exiting;
        logic   fs_next;
        logic   ofs_done;
    } seq_state_t;

    typedef struct packed {
        insel_e sel;
        logic   ofs_en;
        logic   gain_en;
        logic   valid;
    } fe_ctrl_t;

    function automatic run_e decode_code(input logic [2:0] code);
        case (code)
            CODE_PSC: return MD_PSC;
            CODE_BG:  return MD_BG;
            CODE_SFS: return MD_SFS;
            default:  return MD_NONE;
        endcase
    endfunction

    function automatic logic is_timed(input phase_e p);
        return (p == PH_OFS) || (p == PH_GAIN) || (p == PH_FILL);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cal_period_counter.sv
module cal_period_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             counting,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (strobe) begin
            if (restart) begin
                cnt <= '0;
            end else if (counting) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign last = counting && (cnt >= (len - CNT_W'(1)));

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (strobe && restart) |=> (cnt == '0)); // R12

endmodule

// File: rtl/cal_phase_fsm.sv
module cal_phase_fsm
    import calseq_pkg::*;
#(
    parameter int OFS_CYCLES  = 3,
    parameter int GAIN_CYCLES = 3,
    parameter int FILL_CYCLES = 3,
    parameter int SLAVE_EXTRA = 1,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [2:0]       mode_code,
    input  logic             slave_mode,
    input  logic             last,
    output phase_e           phase_o,
    output run_e             run_o,
    output logic             counting,
    output logic             restart,
    output logic [CNT_W-1:0] len,
    output logic             clr_req
);

    seq_state_t st, nxt;
    run_e       requested;

    assign requested = decode_code(mode_code);
    assign counting  = is_timed(st.phase);
    assign phase_o   = st.phase;
    assign run_o     = st.run;

    always_comb begin
        case (st.phase)
            PH_OFS:  len = CNT_W'(OFS_CYCLES + ((slave_mode && !st.ofs_done) ? SLAVE_EXTRA : 0));
            PH_GAIN: len = CNT_W'(GAIN_CYCLES);
            default: len = CNT_W'(FILL_CYCLES);
        endcase
    end

    always_comb begin
        nxt     = st;
        restart = 1'b0;
        clr_req = 1'b0;
        if (strobe) begin
            if (st.phase == PH_NORM) begin
                case (requested)
                    MD_PSC: begin
                        nxt.phase    = PH_OFS;
                        nxt.run      = MD_PSC;
                        nxt.ofs_done = 1'b0;
                        nxt.exiting  = 1'b0;
                        restart      = 1'b1;
                    end
                    MD_BG: begin
                        nxt.phase    = PH_OFS;
                        nxt.run      = MD_BG;
                        nxt.ofs_done = 1'b0;
                        nxt.exiting  = 1'b0;
                        nxt.fs_next  = 1'b1;
                        restart      = 1'b1;
                    end
                    MD_SFS: begin
                        nxt.phase    = PH_GAIN;
                        nxt.run      = MD_SFS;
                        nxt.ofs_done = 1'b0;
                        nxt.exiting  = 1'b0;
                        restart      = 1'b1;
                    end
                    default: ;
                endcase
            end else if (st.run == MD_BG && !st.exiting && requested != MD_BG) begin
                nxt.phase   = PH_FILL;
                nxt.exiting = 1'b1;
                restart     = 1'b1;
            end else begin
                case (st.phase)
                    PH_OFS: if (last) begin
                        nxt.ofs_done = 1'b1;
                        nxt.phase    = (st.run == MD_PSC) ? PH_GAIN : PH_FILL;
                        restart      = 1'b1;
                    end
                    PH_GAIN: if (last) begin
                        restart = 1'b1;
                        if (st.run == MD_BG) begin
                            nxt.phase = PH_FILL;
                        end else if (st.run == MD_PSC) begin
                            nxt.phase = PH_FILL;
                            clr_req   = 1'b1;
                        end else begin
                            nxt.phase = PH_NORM;
                            nxt.run   = MD_NONE;
                            clr_req   = 1'b1;
                        end
                    end
                    PH_FILL: if (last) begin
                        restart = 1'b1;
                        if (st.exiting || st.run != MD_BG) begin
                            nxt.phase   = PH_NORM;
                            nxt.run     = MD_NONE;
                            nxt.exiting = 1'b0;
                        end else begin
                            nxt.phase = PH_VALID;
                        end
                    end
                    PH_VALID: begin
                        restart     = 1'b1;
                        nxt.phase   = st.fs_next ? PH_GAIN : PH_OFS;
                        nxt.fs_next = !st.fs_next;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{phase: PH_FILL, run: MD_NONE, exiting: 1'b0,
                    fs_next: 1'b0, ofs_done: 1'b0};
        end else begin
            st <= nxt;
        end
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(st)); // R12

    AST_NO_CLR_IN_BG: assert property (@(posedge clk) disable iff (rst)
        clr_req |-> (st.run != MD_BG)); // R9

    AST_SFS_RESUMES: assert property (@(posedge clk) disable iff (rst)
        (clr_req && st.run == MD_SFS) |=> (st.phase == PH_NORM)); // R11

endmodule

// File: rtl/cal_ctrl_decode.sv
module cal_ctrl_decode
    import calseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_e     phase,
    input  run_e       run,
    input  logic       clr_req,
    output logic [1:0] in_sel,
    output logic       ofs_cal_en,
    output logic       gain_cal_en,
    output logic       drdy_n,
    output logic       mode_clr
);

    fe_ctrl_t ctrl;

    always_comb begin
        ctrl = '{sel: SEL_INPUT, ofs_en: 1'b0, gain_en: 1'b0, valid: 1'b0};
        case (phase)
            PH_OFS: begin
                ctrl.ofs_en = 1'b1;
                ctrl.sel    = (run == MD_BG) ? SEL_SHORT : SEL_INPUT;
            end
            PH_GAIN: begin
                ctrl.gain_en = 1'b1;
                ctrl.sel     = (run == MD_SFS) ? SEL_INPUT : SEL_REF;
            end
            PH_NORM, PH_VALID: ctrl.valid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_clr <= 1'b0;
        end else begin
            mode_clr <= clr_req;
        end
    end

    assign in_sel      = ctrl.sel;
    assign ofs_cal_en  = ctrl.ofs_en;
    assign gain_cal_en = ctrl.gain_en;
    assign drdy_n      = !ctrl.valid;

    AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ofs_cal_en && gain_cal_en)); // R3

    AST_DRDY_HIGH_IN_CAL: assert property (@(posedge clk) disable iff (rst)
        (ofs_cal_en || gain_cal_en) |-> drdy_n); // R3

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mode_clr |=> !mode_clr); // R5

    AST_SHORT_ONLY_OFS: assert property (@(posedge clk) disable iff (rst)
        (in_sel == SEL_SHORT) |-> ofs_cal_en); // R7

endmodule

// File: rtl/calseq_top.sv
module calseq_top
    import calseq_pkg::*;
#(
    parameter int OFS_CYCLES  = 3,
    parameter int GAIN_CYCLES = 3,
    parameter int FILL_CYCLES = 3,
    parameter int SLAVE_EXTRA = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_code,
    input  logic       conv_strobe,
    input  logic       slave_mode,
    output logic [1:0] in_sel,
    output logic       ofs_cal_en,
    output logic       gain_cal_en,
    output logic       drdy_n,
    output logic       mode_clr
);

    localparam int MAX_LEN = max3(OFS_CYCLES + SLAVE_EXTRA, GAIN_CYCLES, FILL_CYCLES);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_e           phase;
    run_e             run;
    logic             counting;
    logic             restart;
    logic             last;
    logic             clr_req;
    logic [CNT_W-1:0] len;

    cal_phase_fsm #(
        .OFS_CYCLES (OFS_CYCLES),
        .GAIN_CYCLES(GAIN_CYCLES),
        .FILL_CYCLES(FILL_CYCLES),
        .SLAVE_EXTRA(SLAVE_EXTRA),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .strobe    (conv_strobe),
        .mode_code (mode_code),
        .slave_mode(slave_mode),
        .last      (last),
        .phase_o   (phase),
        .run_o     (run),
        .counting  (counting),
        .restart   (restart),
        .len       (len),
        .clr_req   (clr_req)
    );

    cal_period_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .strobe  (conv_strobe),
        .counting(counting),
        .restart (restart),
        .len     (len),
        .last    (last)
    );

    cal_ctrl_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .run        (run),
        .clr_req    (clr_req),
        .in_sel     (in_sel),
        .ofs_cal_en (ofs_cal_en),
        .gain_cal_en(gain_cal_en),
        .drdy_n     (drdy_n),
        .mode_clr   (mode_clr)
    );

endmodule

// File: tb/tb_calseq_top.sv
`timescale 1ns/1ps
module tb_calseq_top;

    localparam logic [1:0] S_IN  = 2'b00;
    localparam logic [1:0] S_SH  = 2'b01;
    localparam logic [1:0] S_REF = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_code = 3'b000;
    logic       conv_strobe = 1'b0;
    logic       slave_mode = 1'b0;
    logic [1:0] in_sel;
    logic       ofs_cal_en, gain_cal_en, drdy_n, mode_clr;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    calseq_top dut (
        .clk        (clk),
        .rst        (rst),
        .mode_code  (mode_code),
        .conv_strobe(conv_strobe),
        .slave_mode (slave_mode),
        .in_sel     (in_sel),
        .ofs_cal_en (ofs_cal_en),
        .gain_cal_en(gain_cal_en),
        .drdy_n     (drdy_n),
        .mode_clr   (mode_clr)
    );

    task automatic expect_out(input string tag, input logic [1:0] s, input logic o,
                              input logic g, input logic d, input logic c);
        logic [5:0] act, exp;
        act = {in_sel, ofs_cal_en, gain_cal_en, drdy_n, mode_clr};
        exp = {s, o, g, d, c};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {sel,ofs,gain,drdy_n,clr} actual %b expected %b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic pulse();
        repeat (2) @(negedge clk);
        conv_strobe = 1'b1;
        @(negedge clk);
        conv_strobe = 1'b0;
    endtask

    task automatic run_phase(input string tag, input int n, input logic [1:0] s,
                             input logic o, input logic g, input logic d);
        for (int i = 0; i < n; i++) begin
            pulse();
            expect_out(tag, s, o, g, d, 1'b0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1 reset", S_IN, 1'b0, 1'b0, 1'b1, 1'b0);
        run_phase("R1 refill", 2, S_IN, 1'b0, 1'b0, 1'b1);
        run_phase("R1 ready", 1, S_IN, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_other_codes();
        logic [2:0] codes [4] = '{3'b001, 3'b010, 3'b110, 3'b111};
        for (int i = 0; i < 4; i++) begin
            mode_code = codes[i];
            pulse();
            expect_out("R2 other code", S_IN, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        mode_code = 3'b100;
        repeat (5) @(negedge clk);
        expect_out("R12 no strobe", S_IN, 1'b0, 1'b0, 1'b0, 1'b0);
        mode_code = 3'b000;
        pulse();
        expect_out("R2 normal", S_IN, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_pseudo(input logic slave);
        slave_mode = slave;
        mode_code  = 3'b100;
        run_phase("R3 R4 offset", slave ? 4 : 3, S_IN, 1'b1, 1'b0, 1'b1);
        run_phase("R5 gain", 3, S_REF, 1'b0, 1'b1, 1'b1);
        pulse();
        expect_out("R5 clear", S_IN, 1'b0, 1'b0, 1'b1, 1'b1);
        mode_code = 3'b000;
        @(negedge clk);
        expect_out("R5 clear width", S_IN, 1'b0, 1'b0, 1'b1, 1'b0);
        run_phase("R6 refill", 2, S_IN, 1'b0, 1'b0, 1'b1);
        run_phase("R6 ready", 1, S_IN, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_background(input logic slave);
        slave_mode = slave;
        mode_code  = 3'b101;
        run_phase("R3 R7 first offset", slave ? 4 : 3, S_SH, 1'b1, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        expect_out("R12 hold", S_SH, 1'b1, 1'b0, 1'b1, 1'b0);
        run_phase("R8 refill", 3, S_IN, 1'b0, 1'b0, 1'b1);
        run_phase("R8 valid", 1, S_IN, 1'b0, 1'b0, 1'b0);
        run_phase("R9 fullscale", 3, S_REF, 1'b0, 1'b1, 1'b1);
        run_phase("R9 refill", 3, S_IN, 1'b0, 1'b0, 1'b1);
        run_phase("R9 valid", 1, S_IN, 1'b0, 1'b0, 0);
        run_phase("R7 later offset", 3, S_SH, 1'b1, 1'b0, 1'b1);
        run_phase("R8 refill 2", 3, S_IN, 1'b0, 1'b0, 1'b1);
        run_phase("R8 valid 2", 1, S_IN, 1'b0, 1'b0, 1'b0);
        run_phase("R9 fullscale 2", 1, S_REF, 1'b0, 1'b1, 1'b1);
        mode_code = 3'b000;
        run_phase("R10 exit refill", 3, S_IN, 1'b0, 1'b0, 1'b1);
        run_phase("R10 normal", 2, S_IN, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_sysfs();
        slave_mode = 1'b1;
        mode_code  = 3'b011;
        run_phase("R11 gain", 3, S_IN, 1'b0, 1'b1, 1'b1);
        pulse();
        expect_out("R11 resume", S_IN, 1'b0, 1'b0, 1'b0, 1'b1);
        mode_code = 3'b000;
        pulse();
        expect_out("R11 after", S_IN, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_other_codes();
        t_pseudo(1'b0);
        t_pseudo(1'b1);
        t_background(1'b0);
        t_background(1'b1);
        t_sysfs();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule